// File: doc/BRIEF.md
# Two-Level I/O Address Translator

This block sits between I/O devices and main memory and turns device bus addresses into physical addresses. The upper part of a bus address picks one of 64 on-chip first-level entries, each covering a 32 MiB region. A first-level entry is one of three kinds. An invalid entry faults. A big-page entry maps its whole region linearly. A table entry points at a second-level table in memory, and that table holds one 32-bit word for each 4 KiB page of the region. The page offset is never altered. Second-level results are kept in a small fully associative cache, so a repeated page does not read memory again.

Software programs the block through a register port. That port holds a command register with the translation enable bit, an address-decode register that selects the window size, the 64 first-level entries, and a write-only register that invalidates cached results for one 16 KiB region. Devices present one request at a time on a valid/ready port and receive a one-cycle response. A table walk issues a single read on the memory port and waits for the returned word.

The walker is a four-state machine:
- IDLE accepts a request. When the request resolves without memory (bypass, cache hit, big page or fault), IDLE moves to RESP. When it needs a second-level word, IDLE moves to FETCH.
- FETCH drives the memory read for one cycle and always moves to WAIT.
- WAIT holds until the read data returns, then moves to RESP.
- RESP presents the result for one cycle and returns to IDLE.

Top module: `iotrans_top`

## Requirements
- R1: The low 12 bits of the request address appear unchanged in bits 11:0 of every non-fault response address.
- R2: When bit 8 of the command register (offset 0x100) is clear, every request is answered in the cycle after acceptance with the request address unchanged, no fault, and the cached and priority outputs at 0.
- R3: Bits 1:0 of the decode register (offset 0x14C) set the window, which is based at address 0: code 0 gives 256 MiB, code 1 gives 2 GiB, code 3 gives 128 GiB, and code 2 behaves like code 0. A request outside the window passes through unchanged, even with translation enabled.
- R4: The first-level entries sit at offsets 0x2B00 + 4*i for i = 0..63. Request bits 30:25 select the entry. A request inside the window with any bit at or above bit 31 set gets a fault.
- R5: A table entry has bit 30 set and bit 31 clear. On a cache miss it causes exactly one memory read, in the cycle after acceptance, of the word at (entry[24:0] << 12) + 4 * request[24:12].
- R6: In a second-level word, bit 31 means valid, bit 30 means cached, and bits 24:0 give the target page. A valid word yields the address {word[24:0], offset}, with the cached output set from bit 30 and the priority output at 0.
- R7: A first-level entry with bits 31 and 30 both clear, or a second-level word with bit 31 clear, gives a fault response. A fault response has address 0 and the cached and priority outputs at 0, and nothing is cached, so a repeat of the same page reads memory again.
- R8: A big-page entry has bit 31 set. It yields the page {entry[24:13], request[24:12]}, with the cached output from bit 1 and the priority output from bit 0, and it reads no memory.
- R9: The cache holds 8 translations and refills them round robin. A hit answers in the cycle after acceptance and reads no memory. The ninth distinct page evicts the first one.
- R10: A write of value V to offset 0x2D00 drops every cached translation whose request bits 36:14 equal V. All other cached translations stay.
- R11: An invalidation that matches the page of a walk still in progress stops that walk's result from being cached. The response itself is still correct.
- R12: req_ready is high only in IDLE. resp_valid and mem_req each last exactly one cycle.
- R13: Offsets 0x100 and 0x14C and the first-level entries read back the last value written, or 0 after reset. Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register byte offset, also the read address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | ADDR_W | Bus address to translate |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fault | output | 1 | Translation fault |
| resp_addr | output | ADDR_W | Physical address (0 on fault) |
| resp_cached | output | 1 | Cached attribute of the mapping |
| resp_prio | output | 1 | Priority attribute of a big-page mapping |
| mem_req | output | 1 | Second-level word read strobe |
| mem_addr | output | ADDR_W | Byte address of the second-level word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Second-level word |

## Verification
The assertions check the handshake shape on every cycle:
- one-cycle response and read strobes;
- ready low while a request is in flight;
- a memory read only right after an acceptance;
- the offset carried through to the result;
- all-zero fault responses;
- bypass while translation is off.

Only the bench scenarios can show that cached translations are reused, that round-robin eviction picks the right victim, and that invalidation drops exactly one 16 KiB region. The same holds for dropping the fill of a walk that an invalidation overtakes and for the window boundaries. The bench shows these by sweeping every first-level entry with several pages each and by counting memory reads per request.

// File: rtl/iotrans_pkg.sv
package iotrans_pkg;
    localparam int L1_NUM     = 64;
    localparam int L1_IDX_W   = 6;
    localparam int PAGE_SH    = 12;
    localparam int REGION_SH  = 25;
    localparam int COVER_SH   = REGION_SH + L1_IDX_W;
    localparam int INV_SH     = 14;
    localparam int RA_W       = 14;

    localparam logic [RA_W-1:0] OFS_CMD    = 14'h0100;
    localparam logic [RA_W-1:0] OFS_DEC    = 14'h014C;
    localparam logic [RA_W-1:0] OFS_L1     = 14'h2B00;
    localparam logic [RA_W-1:0] OFS_INVAL  = 14'h2D00;

    localparam int CMD_EN_BIT   = 8;
    localparam int L1_BIG_BIT   = 31;
    localparam int L1_TBL_BIT   = 30;
    localparam int L2_OK_BIT    = 31;
    localparam int L2_CACHE_BIT = 30;
    localparam int BIG_BASE_LO  = 13;

    localparam logic [1:0] WIN_2G   = 2'd1;
    localparam logic [1:0] WIN_128G = 2'd3;

    typedef enum logic [1:0] {
        S_IDLE,
        S_FETCH,
        S_WAIT,
        S_RESP
    } walk_st_e;

    typedef enum logic [2:0] {
        K_PASS,
        K_HIT,
        K_BIG,
        K_MISS,
        K_FAULT
    } kind_e;
endpackage

// File: rtl/iotrans_regs.sv
module iotrans_regs
    import iotrans_pkg::*;
#(
    parameter int INV_W = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [RA_W-1:0]     reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic                xlate_en,
    output logic [1:0]          win_code,
    input  logic [L1_IDX_W-1:0] l1_idx,
    output logic [31:0]         l1_entry,
    output logic                inv_en,
    output logic [INV_W-1:0]    inv_key
);
    logic [31:0] cmd_q;
    logic [31:0] dec_q;
    logic [31:0] l1_q [L1_NUM];

    logic hit_l1;
    logic [L1_IDX_W-1:0] wr_idx;

    assign hit_l1 = (reg_addr[RA_W-1:8] == OFS_L1[RA_W-1:8]);
    assign wr_idx = reg_addr[L1_IDX_W+1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
            dec_q <= '0;
            for (int i = 0; i < L1_NUM; i++) l1_q[i] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_CMD) cmd_q <= reg_wdata;
            if (reg_addr == OFS_DEC) dec_q <= reg_wdata;
            if (hit_l1) l1_q[wr_idx] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CMD)      reg_rdata = cmd_q;
        else if (reg_addr == OFS_DEC) reg_rdata = dec_q;
        else if (hit_l1)              reg_rdata = l1_q[wr_idx];
    end

    assign xlate_en = cmd_q[CMD_EN_BIT];
    assign win_code = dec_q[1:0];
    assign l1_entry = l1_q[l1_idx];
    assign inv_en   = reg_wr && (reg_addr == OFS_INVAL);
    assign inv_key  = reg_wdata[INV_W-1:0];
endmodule

// File: rtl/iotrans_tlb.sv
module iotrans_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 25,
    parameter int PPN_W   = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [PPN_W-1:0]   lk_ppn,
    output logic               lk_cached,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    input  logic               fill_cached,
    input  logic               inv_en,
    input  logic [VPN_W-3:0]   inv_key
);
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [PTR_W-1:0]  ptr_q;
    logic [ENTRIES-1:0] match;
    logic [PPN_W-1:0]  slot_ppn [ENTRIES];
    logic [ENTRIES-1:0] slot_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (fill_en) begin
            ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic             v_q;
        logic [VPN_W-1:0] vpn_q;
        logic [PPN_W-1:0] ppn_q;
        logic             c_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q   <= 1'b0;
                vpn_q <= '0;
                ppn_q <= '0;
                c_q   <= 1'b0;
            end else if (fill_en && ptr_q == PTR_W'(g)) begin
                v_q   <= 1'b1;
                vpn_q <= fill_vpn;
                ppn_q <= fill_ppn;
                c_q   <= fill_cached;
            end else if (inv_en && vpn_q[VPN_W-1:2] == inv_key) begin
                v_q   <= 1'b0;
            end
        end

        assign match[g]    = v_q && (vpn_q == lk_vpn);
        assign slot_ppn[g] = ppn_q;
        assign slot_c[g]   = c_q;
    end

    always_comb begin
        lk_ppn    = '0;
        lk_cached = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_ppn    = lk_ppn | slot_ppn[i];
                lk_cached = lk_cached | slot_c[i];
            end
        end
    end

    assign lk_hit = |match;
endmodule

// File: rtl/iotrans_walk.sv
module iotrans_walk
    import iotrans_pkg::*;
#(
    parameter int ADDR_W = 37
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    output logic                  req_ready,
    output logic                  resp_valid,
    output logic                  resp_fault,
    output logic [ADDR_W-1:0]     resp_addr,
    output logic                  resp_cached,
    output logic                  resp_prio,
    output logic                  mem_req,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic                  mem_rvalid,
    input  logic [31:0]           mem_rdata,
    input  logic                  xlate_en,
    input  logic [1:0]            win_code,
    output logic [L1_IDX_W-1:0]   l1_idx,
    input  logic [31:0]           l1_entry,
    output logic [ADDR_W-PAGE_SH-1:0] lk_vpn,
    input  logic                  lk_hit,
    input  logic [ADDR_W-PAGE_SH-1:0] lk_ppn,
    input  logic                  lk_cached,
    output logic                  fill_en,
    output logic [ADDR_W-PAGE_SH-1:0] fill_vpn,
    output logic [ADDR_W-PAGE_SH-1:0] fill_ppn,
    output logic                  fill_cached,
    input  logic                  inv_en,
    input  logic [ADDR_W-INV_SH-1:0] inv_key
);
    localparam int PPN_W = ADDR_W - PAGE_SH;
    localparam int L2I_W = REGION_SH - PAGE_SH;

    walk_st_e st_q, st_d;
    kind_e    kind;
    logic     in_win;
    logic     inv_hit_req;
    logic     inv_hit_cur;

    logic [PPN_W-1:0]   r_vpn;
    logic [PPN_W-1:0]   r_ppn;
    logic [PAGE_SH-1:0] r_off;
    logic [ADDR_W-1:0]  r_l2addr;
    logic               r_fault;
    logic               r_cached;
    logic               r_prio;
    logic               r_drop;
    logic [ADDR_W-1:0]  l2_addr;

    assign l1_idx  = req_addr[COVER_SH-1:REGION_SH];
    assign lk_vpn  = req_addr[ADDR_W-1:PAGE_SH];
    assign l2_addr = {l1_entry[PPN_W-1:0], {PAGE_SH{1'b0}}}
                   + ADDR_W'({req_addr[REGION_SH-1:PAGE_SH], 2'b00});

    assign inv_hit_req = inv_en && (inv_key == req_addr[ADDR_W-1:INV_SH]);
    assign inv_hit_cur = inv_en && (inv_key == r_vpn[PPN_W-1:INV_SH-PAGE_SH]);

    // Window and entry decode for the request offered in IDLE
    always_comb begin
        unique case (win_code)
            WIN_2G:   in_win = ~|req_addr[ADDR_W-1:31];
            WIN_128G: in_win = 1'b1;
            default:  in_win = ~|req_addr[ADDR_W-1:28];
        endcase
        if (!xlate_en || !in_win)              kind = K_PASS;
        else if (|req_addr[ADDR_W-1:COVER_SH]) kind = K_FAULT;
        else if (lk_hit)                       kind = K_HIT;
        else if (l1_entry[L1_BIG_BIT])         kind = K_BIG;
        else if (l1_entry[L1_TBL_BIT])         kind = K_MISS;
        else                                   kind = K_FAULT;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (req_valid) st_d = (kind == K_MISS) ? S_FETCH : S_RESP;
            S_FETCH: st_d = S_WAIT;
            S_WAIT:  if (mem_rvalid) st_d = S_RESP;
            S_RESP:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_vpn    <= '0;
            r_ppn    <= '0;
            r_off    <= '0;
            r_l2addr <= '0;
            r_fault  <= 1'b0;
            r_cached <= 1'b0;
            r_prio   <= 1'b0;
            r_drop   <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: if (req_valid) begin
                    r_off    <= req_addr[PAGE_SH-1:0];
                    r_vpn    <= req_addr[ADDR_W-1:PAGE_SH];
                    r_l2addr <= l2_addr;
                    r_drop   <= inv_hit_req;
                    r_fault  <= 1'b0;
                    r_cached <= 1'b0;
                    r_prio   <= 1'b0;
                    r_ppn    <= '0;
                    unique case (kind)
                        K_PASS:  r_ppn <= req_addr[ADDR_W-1:PAGE_SH];
                        K_HIT: begin
                            r_ppn    <= lk_ppn;
                            r_cached <= lk_cached;
                        end
                        K_BIG: begin
                            r_ppn    <= {l1_entry[PPN_W-1:BIG_BASE_LO],
                                         req_addr[REGION_SH-1:PAGE_SH]};
                            r_cached <= l1_entry[1];
                            r_prio   <= l1_entry[0];
                        end
                        K_FAULT: r_fault <= 1'b1;
                        default: r_ppn <= '0;
                    endcase
                end
                S_FETCH: if (inv_hit_cur) r_drop <= 1'b1;
                S_WAIT: begin
                    if (inv_hit_cur) r_drop <= 1'b1;
                    if (mem_rvalid) begin
                        r_fault  <= ~mem_rdata[L2_OK_BIT];
                        r_ppn    <= mem_rdata[L2_OK_BIT] ? mem_rdata[PPN_W-1:0] : '0;
                        r_cached <= mem_rdata[L2_OK_BIT] & mem_rdata[L2_CACHE_BIT];
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready  = (st_q == S_IDLE);
        resp_valid = (st_q == S_RESP);
        mem_req    = (st_q == S_FETCH);
    end

    assign mem_addr    = r_l2addr;
    assign resp_fault  = r_fault;
    assign resp_addr   = r_fault ? '0 : {r_ppn, r_off};
    assign resp_cached = r_cached;
    assign resp_prio   = r_prio;

    assign fill_en     = (st_q == S_WAIT) && mem_rvalid && mem_rdata[L2_OK_BIT]
                       && !r_drop && !inv_hit_cur;
    assign fill_vpn    = r_vpn;
    assign fill_ppn    = mem_rdata[PPN_W-1:0];
    assign fill_cached = mem_rdata[L2_CACHE_BIT];

    if (L2I_W != 13) begin : g_bad_cfg
        initial $error("region and page sizes disagree");
    end
endmodule

// File: rtl/iotrans_top.sv
module iotrans_top
    import iotrans_pkg::*;
#(
    parameter int ADDR_W      = 37,
    parameter int TLB_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [13:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_fault,
    output logic [ADDR_W-1:0] resp_addr,
    output logic              resp_cached,
    output logic              resp_prio,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    localparam int PPN_W = ADDR_W - PAGE_SH;
    localparam int INV_W = ADDR_W - INV_SH;

    logic                xlate_en;
    logic [1:0]          win_code;
    logic [L1_IDX_W-1:0] l1_idx;
    logic [31:0]         l1_entry;
    logic                inv_en;
    logic [INV_W-1:0]    inv_key;
    logic [PPN_W-1:0]    lk_vpn, lk_ppn, fill_vpn, fill_ppn;
    logic                lk_hit, lk_cached, fill_en, fill_cached;

    iotrans_regs #(.INV_W(INV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xlate_en(xlate_en),
        .win_code(win_code), .l1_idx(l1_idx), .l1_entry(l1_entry),
        .inv_en(inv_en), .inv_key(inv_key)
    );

    iotrans_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(PPN_W), .PPN_W(PPN_W)) u_tlb (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_ppn(lk_ppn), .lk_cached(lk_cached), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_cached(fill_cached),
        .inv_en(inv_en), .inv_key(inv_key)
    );

    iotrans_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_fault(resp_fault),
        .resp_addr(resp_addr), .resp_cached(resp_cached), .resp_prio(resp_prio),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .xlate_en(xlate_en), .win_code(win_code),
        .l1_idx(l1_idx), .l1_entry(l1_entry), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
        .lk_ppn(lk_ppn), .lk_cached(lk_cached), .fill_en(fill_en),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_cached(fill_cached),
        .inv_en(inv_en), .inv_key(inv_key)
    );
endmodule

// File: rtl/iotrans_chk.sv
module iotrans_chk #(
    parameter int ADDR_W = 37
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [13:0]       reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_fault,
    input logic [ADDR_W-1:0] resp_addr,
    input logic              resp_cached,
    input logic              resp_prio,
    input logic              mem_req
);
    logic [11:0] off_q;
    logic        en_q;
    logic        acc;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (acc) off_q <= req_addr[11:0];
            if (reg_wr && reg_addr == 14'h0100) en_q <= reg_wdata[8];
        end
    end

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> resp_addr[11:0] == off_q); // R1
    AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !en_q) |=> (resp_valid && !resp_fault && resp_addr == $past(req_addr)
                            && !resp_cached && !resp_prio)); // R2
    AST_FETCH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(acc)); // R5
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_addr == '0 && !resp_cached && !resp_prio)); // R7
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R12
    AST_MEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R12
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R12
    AST_NOT_READY_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || mem_req) |-> !req_ready); // R12
endmodule

bind iotrans_top iotrans_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_fault(resp_fault),
    .resp_addr(resp_addr), .resp_cached(resp_cached), .resp_prio(resp_prio),
    .mem_req(mem_req)
);

// File: tb/sim_iotrans_top.sv
module sim_iotrans_top;
    localparam int AW = 37;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [13:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_ready, resp_valid, resp_fault, resp_cached, resp_prio;
    logic [AW-1:0] resp_addr, mem_addr;
    logic          mem_req;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;

    always #5 clk = ~clk;

    iotrans_top #(.ADDR_W(AW), .TLB_ENTRIES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_addr(req_addr), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_fault(resp_fault), .resp_addr(resp_addr), .resp_cached(resp_cached),
        .resp_prio(resp_prio), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    int mem_reads = 0;
    int mcnt = 0;
    logic [AW-1:0] maddr = '0;
    logic [31:0] l1_sh [64];
    logic en_sh = 1'b0;
    logic [1:0] win_sh = 2'd0;

    // Second-level memory content: a fixed arithmetic pattern
    function automatic logic [31:0] mem_word(logic [AW-1:0] a);
        logic [18:0] hv;
        int h;
        logic [24:0] ppn;
        hv = a[20:2];
        h = int'(hv);
        ppn = 25'(h * 37 + 11);
        return {((h % 5) != 4), hv[0], 5'b0, ppn};
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            mem_reads <= mem_reads + 1;
            maddr <= mem_addr;
            mcnt <= 3;
        end else if (mcnt > 0) begin
            mcnt <= mcnt - 1;
            if (mcnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata <= mem_word(maddr);
            end
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Expected result from the requirements
    task automatic expect_for(input logic [AW-1:0] a, output logic [AW+2:0] e);
        logic in_win;
        logic [31:0] ent, w;
        logic [AW-1:0] la;
        in_win = (win_sh == 2'd1) ? (a[AW-1:31] == 0) :
                 (win_sh == 2'd3) ? 1'b1 : (a[AW-1:28] == 0);
        if (!en_sh || !in_win) e = {3'b000, a};
        else if (a[AW-1:31] != 0) e = {3'b100, {AW{1'b0}}};
        else begin
            ent = l1_sh[a[30:25]];
            if (ent[31]) e = {1'b0, ent[1], ent[0], ent[24:13], a[24:12], a[11:0]};
            else if (ent[30]) begin
                la = {ent[24:0], 12'b0} + AW'({a[24:12], 2'b00});
                w = mem_word(la);
                if (!w[31]) e = {3'b100, {AW{1'b0}}};
                else e = {1'b0, w[30], 1'b0, w[24:0], a[11:0]};
            end else e = {3'b100, {AW{1'b0}}};
        end
    endtask

    task automatic xlate(input logic [AW-1:0] a, output logic [AW+2:0] got,
                         output int reads, output int lat);
        int r0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        r0 = mem_reads;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
        got = {resp_fault, resp_cached, resp_prio, resp_addr};
        reads = mem_reads - r0;
        @(negedge clk);
        chk("R12 resp_valid single cycle", 128'(resp_valid), 128'(0));
    endtask

    function automatic logic [31:0] l1_val(int i);
        case (i % 4)
            0: return 32'h0;
            2: return 32'h8000_0000 | (32'(i + 100) << 13) | 32'((i >> 2) & 3);
            default: return 32'h4000_0000 | 32'(32'h10000 + i * 8);
        endcase
    endfunction

    task automatic setup();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) begin
            l1_sh[i] = l1_val(i);
            wr(14'(14'h2B00 + i * 4), l1_sh[i]);
        end
        wr(14'h0100, 32'h100); en_sh = 1'b1;
        wr(14'h014C, 32'h1);   win_sh = 2'd1;
    endtask

    function automatic logic [AW-1:0] page_addr(int region, int idx, int off);
        return (AW'(region) << 25) | (AW'(idx) << 12) | AW'(off);
    endfunction

    function automatic int pick_valid(int k);
        logic [AW-1:0] la;
        logic [31:0] w;
        for (int j = 0; j < 4; j++) begin
            la = {l1_val(1)[24:0], 12'b0} + AW'((4 * k + j) * 4);
            w = mem_word(la);
            if (w[31]) return 4 * k + j;
        end
        return 4 * k;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [AW+2:0] got, exp;
        logic [AW-1:0] a, q;
        int reads, lat, pg[9], bad;

        // Reset state
        repeat (2) @(negedge clk);
        chk("R12 ready in reset", 128'(req_ready), 128'(1));
        chk("R12 no resp in reset", 128'({resp_valid, mem_req}), 128'(0));
        rst_n = 1'b1;
        rd(14'h0100, d); chk("R13 cmd reset", 128'(d), 128'(0));
        rd(14'h2B14, d); chk("R13 l1 reset", 128'(d), 128'(0));

        setup();
        rd(14'h2B14, d); chk("R13 l1 readback", 128'(d), 128'(l1_sh[5]));
        rd(14'h014C, d); chk("R13 dec readback", 128'(d), 128'(1));
        rd(14'h0100, d); chk("R13 cmd readback", 128'(d), 128'(32'h100));
        rd(14'h2D00, d); chk("R13 inval reads 0", 128'(d), 128'(0));
        rd(14'h0000, d); chk("R13 unmapped reads 0", 128'(d), 128'(0));

        // Sweep every first-level entry with three distinct pages
        for (int i = 0; i < 64; i++) begin
            for (int s = 0; s < 3; s++) begin
                a = page_addr(i, (s * 2731 + i) % 8192, (i * 17 + s * 901) % 4096);
                xlate(a, got, reads, lat);
                expect_for(a, exp);
                case (i % 4)
                    0: begin
                        chk("R7 invalid L1 result", 128'(got), 128'(exp));
                        chk("R7 invalid L1 no read", 128'(reads), 128'(0));
                    end
                    2: begin
                        chk("R8 big page result R1 R4", 128'(got), 128'(exp));
                        chk("R8 big page no read", 128'(reads), 128'(0));
                    end
                    default: begin
                        chk("R6 table result R1 R4", 128'(got), 128'(exp));
                        chk("R5 one read per miss", 128'(reads), 128'(1));
                    end
                endcase
            end
        end

        // Windows
        a = AW'(37'h0_8000_0456);
        xlate(a, got, reads, lat); chk("R3 outside 2G passes", 128'(got), 128'({3'b000, a}));
        wr(14'h014C, 32'h0); win_sh = 2'd0;
        a = AW'(37'h0_0FFF_F123);
        xlate(a, got, reads, lat); expect_for(a, exp); chk("R3 inside 256M", 128'(got), 128'(exp));
        a = AW'(37'h0_1000_0123);
        xlate(a, got, reads, lat); chk("R3 outside 256M passes", 128'(got), 128'({3'b000, a}));
        wr(14'h014C, 32'h2); win_sh = 2'd2;
        xlate(a, got, reads, lat); chk("R3 code 2 as 256M", 128'(got), 128'({3'b000, a}));
        wr(14'h014C, 32'h3); win_sh = 2'd3;
        a = AW'(37'h0_8000_0000);
        xlate(a, got, reads, lat); chk("R4 beyond table faults", 128'(got), 128'({3'b100, {AW{1'b0}}}));
        a = AW'(37'h1F_0000_0ABC);
        xlate(a, got, reads, lat); chk("R4 high address faults", 128'(got), 128'({3'b100, {AW{1'b0}}}));
        a = page_addr(6, 77, 12'h3C5);
        xlate(a, got, reads, lat); expect_for(a, exp); chk("R3 128G big page", 128'(got), 128'(exp));

        // Translation disabled
        wr(14'h0100, 32'h0); en_sh = 1'b0;
        a = AW'(37'h0_0000_1234);
        xlate(a, got, reads, lat); chk("R2 bypass invalid region", 128'(got), 128'({3'b000, a}));
        chk("R2 bypass latency", 128'(lat), 128'(1));
        a = AW'(37'h1A_BCDE_F012);
        xlate(a, got, reads, lat); chk("R2 bypass high address", 128'(got), 128'({3'b000, a}));

        // Cache reuse and round-robin eviction
        setup();
        for (int k = 0; k < 9; k++) begin
            pg[k] = pick_valid(k);
            a = page_addr(1, pg[k], k * 100);
            xlate(a, got, reads, lat);
            chk("R9 first access reads", 128'(reads), 128'(1));
        end
        for (int k = 1; k < 9; k++) begin
            a = page_addr(1, pg[k], k * 7 + 1);
            xlate(a, got, reads, lat); expect_for(a, exp);
            chk("R9 hit result", 128'(got), 128'(exp));
            chk("R9 hit no read", 128'(reads), 128'(0));
            chk("R9 hit latency", 128'(lat), 128'(1));
        end
        a = page_addr(1, pg[0], 5);
        xlate(a, got, reads, lat); chk("R9 ninth page evicted first", 128'(reads), 128'(1));

        // Region invalidation
        wr(14'h2D00, 32'(page_addr(1, pg[3], 0) >> 14));
        a = page_addr(1, pg[3], 9);
        xlate(a, got, reads, lat); expect_for(a, exp);
        chk("R10 dropped page refetched", 128'(reads), 128'(1));
        chk("R10 refetch result", 128'(got), 128'(exp));
        a = page_addr(1, pg[4], 9);
        xlate(a, got, reads, lat); chk("R10 other page kept", 128'(reads), 128'(0));

        // Invalid second-level word is not cached
        bad = 40;
        for (int j = 40; j < 80; j++) begin
            if (!mem_word({l1_sh[1][24:0], 12'b0} + AW'(j * 4))[31]) begin
                bad = j;
                break;
            end
        end
        a = page_addr(1, bad, 3);
        xlate(a, got, reads, lat);
        chk("R7 invalid L2 faults", 128'(got), 128'({3'b100, {AW{1'b0}}}));
        xlate(a, got, reads, lat);
        chk("R7 invalid L2 not cached", 128'(reads), 128'(1));

        // Invalidation overtaking a walk
        q = page_addr(1, pick_valid(30), 12'h2A);
        fork
            xlate(q, got, reads, lat);
            begin
                do @(negedge clk); while (!mem_req);
                wr(14'h2D00, 32'(q >> 14));
            end
        join
        expect_for(q, exp);
        chk("R11 response still correct", 128'(got), 128'(exp));
        xlate(q, got, reads, lat); chk("R11 fill dropped", 128'(reads), 128'(1));
        xlate(q, got, reads, lat); chk("R11 later fill kept", 128'(reads), 128'(0));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule